// File: doc/BRIEF.md
# Bridge Reset Handshake Sequencer

This block steps a fabric-to-memory bridge through a safe reset and back into service. One start pulse begins a run. If the handshake enable is set when the start is taken, the sequencer first raises a warning request toward the fabric. It then waits for the fabric to acknowledge, which tells it that the fabric has stopped sending traffic. Next it raises a flush request so the bridge fences and drains what it still holds. When the flush acknowledge arrives, it asserts the bridge reset.

The reset is held until the fabric reports that reconfiguration has finished. The sequencer then releases the reset, withdraws the warning request, and withdraws the flush request, one step per cycle. It reports completion only after the flush acknowledge and then the warning acknowledge have both fallen. Each state that waits on an acknowledge is guarded by a programmable cycle limit. When the limit runs out, the sequencer returns to idle and raises a sticky error flag. A code tells which wait failed.

Top module: `bridge_rst_seq`

## Requirements
- R1: The warning handshake runs only if `hs_en_i` is high in the cycle the start is accepted; `fab_req_o` is then high from the next cycle, otherwise it stays low for the whole run.
- R2: While `fab_req_o` waits for its acknowledge, `flush_req_o` stays low; it rises the cycle after `fab_ack_i` is sampled high.
- R3: With the handshake disabled, `flush_req_o` rises the cycle after the accepted start.
- R4: `bridge_rst_o` stays low until `flush_ack_i` is sampled high while flushing, and is high from the next cycle.
- R5: `bridge_rst_o` stays high until `reconf_done_i` is sampled high, and is low from the next cycle.
- R6: In the cycle the bridge reset is released, both requests are still held. `fab_req_o` falls one cycle later, and `flush_req_o` falls one cycle after that.
- R7: After the requests are withdrawn, the sequencer waits for `flush_ack_i` low and then, if the handshake ran, for `fab_ack_i` low. `done_o` is high for exactly one cycle, in the cycle after the last of these is sampled, and `busy_o` is low in that cycle.
- R8: `busy_o` is high from the cycle after an accepted start until the run ends. A start seen while busy is ignored.
- R9: With `tmo_limit_i` = L > 0, a wait state whose condition is false at L consecutive clock edges ends the run at the L-th edge. The run returns to idle with both requests and the bridge reset low, and `err_o` goes high. `err_state_o` names the failed wait: 1 for the warning acknowledge high, 2 for the flush acknowledge high, 3 for the flush acknowledge low, 4 for the warning acknowledge low. A condition that becomes true at the L-th edge does not time out. `err_o` and `err_state_o` hold their values until the next accepted start or a reset. L = 0 disables the limit.
- R10: Synchronous active-high `rst` returns the block to idle with all outputs low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse |
| hs_en_i | input | 1 | Enables the fabric warning handshake |
| fab_ack_i | input | 1 | Fabric warning acknowledge (level) |
| flush_ack_i | input | 1 | Bridge flush acknowledge (level) |
| reconf_done_i | input | 1 | Fabric reconfiguration finished |
| tmo_limit_i | input | TMO_W | Acknowledge wait limit in cycles, 0 = none |
| fab_req_o | output | 1 | Fabric warning request |
| flush_req_o | output | 1 | Bridge flush request |
| bridge_rst_o | output | 1 | Bridge reset |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Sticky timeout flag |
| err_state_o | output | 3 | Code of the wait that timed out |

## Verification
Every reaction is due exactly one clock edge after the input that causes it is sampled. This holds for a request rising, the reset asserting or releasing, the timeout at the L-th edge, and the done pulse. Each release step adds one more edge. The bench drives inputs just after a falling edge and samples the outputs at the next falling edge, so each stepped check looks at the first cycle in which the new value should appear. A behavioural model updated on every rising edge is also compared with all outputs at every falling edge. This catches any result that arrives one cycle early or late.

// File: rtl/brs_pkg.sv
package brs_pkg;

    typedef enum logic [2:0] {
        PH_IDLE       = 3'd0,
        PH_FAB_WAIT   = 3'd1,
        PH_FLUSH_WAIT = 3'd2,
        PH_RST_HOLD   = 3'd3,
        PH_RELEASED   = 3'd4,
        PH_FAB_CLR    = 3'd5,
        PH_DRAIN_WAIT = 3'd6,
        PH_QUIET_WAIT = 3'd7
    } phase_e;

    typedef enum logic [2:0] {
        TMO_NONE      = 3'd0,
        TMO_FAB_HI    = 3'd1,
        TMO_FLUSH_HI  = 3'd2,
        TMO_FLUSH_LO  = 3'd3,
        TMO_FAB_LO    = 3'd4
    } tmo_src_e;

    typedef struct packed {
        logic fab_req;
        logic flush_req;
        logic bridge_rst;
    } ctl_t;

    function automatic logic is_ack_wait(phase_e p);
        return (p == PH_FAB_WAIT) || (p == PH_FLUSH_WAIT) ||
               (p == PH_DRAIN_WAIT) || (p == PH_QUIET_WAIT);
    endfunction

    function automatic tmo_src_e src_of(phase_e p);
        tmo_src_e s;
        case (p)
            PH_FAB_WAIT:   s = TMO_FAB_HI;
            PH_FLUSH_WAIT: s = TMO_FLUSH_HI;
            PH_DRAIN_WAIT: s = TMO_FLUSH_LO;
            PH_QUIET_WAIT: s = TMO_FAB_LO;
            default:       s = TMO_NONE;
        endcase
        return s;
    endfunction

    function automatic ctl_t drive_of(phase_e p, logic hs);
        ctl_t c;
        c.fab_req    = hs && ((p == PH_FAB_WAIT) || (p == PH_FLUSH_WAIT) ||
                              (p == PH_RST_HOLD) || (p == PH_RELEASED));
        c.flush_req  = (p == PH_FLUSH_WAIT) || (p == PH_RST_HOLD) ||
                       (p == PH_RELEASED) || (p == PH_FAB_CLR);
        c.bridge_rst = (p == PH_RST_HOLD);
        return c;
    endfunction

endpackage

// File: rtl/brs_timer.sv
module brs_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         run,
    input  logic [W-1:0] limit,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (run) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired = run && (limit != '0) && (cnt_q == limit - 1'b1);
endmodule

// File: rtl/brs_fsm.sv
module brs_fsm
    import brs_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     start_i,
    input  logic     hs_en_i,
    input  logic     fab_ack_i,
    input  logic     flush_ack_i,
    input  logic     reconf_done_i,
    input  logic     expired,
    output phase_e   phase_q,
    output phase_e   phase_d,
    output logic     hs_q,
    output logic     tmo_run,
    output logic     done_q,
    output logic     err_q,
    output tmo_src_e code_q
);
    logic met;
    logic accept;
    logic finish;
    logic tmo;

    always_comb begin
        case (phase_q)
            PH_FAB_WAIT:   met = fab_ack_i;
            PH_FLUSH_WAIT: met = flush_ack_i;
            PH_DRAIN_WAIT: met = !flush_ack_i;
            PH_QUIET_WAIT: met = !fab_ack_i;
            default:       met = 1'b0;
        endcase
    end

    assign tmo_run = is_ack_wait(phase_q) && !met;
    assign tmo     = tmo_run && expired;

    always_comb begin
        phase_d = phase_q;
        accept  = 1'b0;
        finish  = 1'b0;
        case (phase_q)
            PH_IDLE: begin
                if (start_i) begin
                    accept  = 1'b1;
                    phase_d = hs_en_i ? PH_FAB_WAIT : PH_FLUSH_WAIT;
                end
            end
            PH_FAB_WAIT:   if (met) phase_d = PH_FLUSH_WAIT;
            PH_FLUSH_WAIT: if (met) phase_d = PH_RST_HOLD;
            PH_RST_HOLD:   if (reconf_done_i) phase_d = PH_RELEASED;
            PH_RELEASED:   phase_d = PH_FAB_CLR;
            PH_FAB_CLR:    phase_d = PH_DRAIN_WAIT;
            PH_DRAIN_WAIT: begin
                if (met) begin
                    if (hs_q) begin
                        phase_d = PH_QUIET_WAIT;
                    end else begin
                        phase_d = PH_IDLE;
                        finish  = 1'b1;
                    end
                end
            end
            PH_QUIET_WAIT: begin
                if (met) begin
                    phase_d = PH_IDLE;
                    finish  = 1'b1;
                end
            end
            default: phase_d = PH_IDLE;
        endcase
        if (tmo) begin
            phase_d = PH_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            hs_q    <= 1'b0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
            code_q  <= TMO_NONE;
        end else begin
            phase_q <= phase_d;
            done_q  <= finish;
            if (accept) begin
                hs_q   <= hs_en_i;
                err_q  <= 1'b0;
                code_q <= TMO_NONE;
            end else if (tmo) begin
                err_q  <= 1'b1;
                code_q <= src_of(phase_q);
            end
        end
    end
endmodule

// File: rtl/brs_ctl.sv
module brs_ctl
    import brs_pkg::*;
(
    input  phase_e phase_q,
    input  logic   hs_q,
    output ctl_t   ctl
);
    assign ctl = drive_of(phase_q, hs_q);
endmodule

// File: rtl/bridge_rst_seq.sv
module bridge_rst_seq
    import brs_pkg::*;
#(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             hs_en_i,
    input  logic             fab_ack_i,
    input  logic             flush_ack_i,
    input  logic             reconf_done_i,
    input  logic [TMO_W-1:0] tmo_limit_i,
    output logic             fab_req_o,
    output logic             flush_req_o,
    output logic             bridge_rst_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             err_o,
    output logic [2:0]       err_state_o
);
    phase_e   phase_q;
    phase_e   phase_d;
    logic     hs_q;
    logic     tmo_run;
    logic     expired;
    logic     done_q;
    logic     err_q;
    tmo_src_e code_q;
    ctl_t     ctl;

    brs_fsm u_fsm (
        .clk           (clk),
        .rst           (rst),
        .start_i       (start_i),
        .hs_en_i       (hs_en_i),
        .fab_ack_i     (fab_ack_i),
        .flush_ack_i   (flush_ack_i),
        .reconf_done_i (reconf_done_i),
        .expired       (expired),
        .phase_q       (phase_q),
        .phase_d       (phase_d),
        .hs_q          (hs_q),
        .tmo_run       (tmo_run),
        .done_q        (done_q),
        .err_q         (err_q),
        .code_q        (code_q)
    );

    brs_timer #(.W(TMO_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .clr     (phase_d != phase_q),
        .run     (tmo_run),
        .limit   (tmo_limit_i),
        .expired (expired)
    );

    brs_ctl u_ctl (
        .phase_q (phase_q),
        .hs_q    (hs_q),
        .ctl     (ctl)
    );

    assign fab_req_o    = ctl.fab_req;
    assign flush_req_o  = ctl.flush_req;
    assign bridge_rst_o = ctl.bridge_rst;
    assign busy_o       = (phase_q != PH_IDLE);
    assign done_o       = done_q;
    assign err_o        = err_q;
    assign err_state_o  = code_q;
endmodule

// File: rtl/brs_checker.sv
module brs_checker (
    input logic       clk,
    input logic       rst,
    input logic       start_i,
    input logic       hs_en_i,
    input logic       fab_ack_i,
    input logic       flush_ack_i,
    input logic       reconf_done_i,
    input logic       fab_req_o,
    input logic       flush_req_o,
    input logic       bridge_rst_o,
    input logic       busy_o,
    input logic       done_o,
    input logic       err_o,
    input logic [2:0] err_state_o
);
    p_fab_rise_r1: assert property (@(posedge clk) disable iff (rst)
        $rose(fab_req_o) |-> ($past(start_i) && $past(hs_en_i) && !$past(busy_o)));

    p_flush_rise_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(flush_req_o) |-> ($past(fab_req_o) ? $past(fab_ack_i)
                                                  : ($past(start_i) && !$past(busy_o))));

    p_rst_after_flush_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(bridge_rst_o) |-> ($past(flush_ack_i) && $past(flush_req_o)));

    p_rst_release_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(bridge_rst_o) |-> ($past(reconf_done_i) || $past(rst)));

    p_release_order_r6: assert property (@(posedge clk) disable iff (rst)
        ($fell(flush_req_o) && !err_o && !$past(rst)) |-> (!fab_req_o && !bridge_rst_o));

    p_done_idle_r7: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (!busy_o && !fab_req_o && !flush_req_o && !bridge_rst_o));

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    p_timeout_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(err_o) |-> (!busy_o && !bridge_rst_o && (err_state_o != 3'd0)));

    p_err_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (err_o && !start_i) |=> err_o);

    p_reset_r10: assert property (@(posedge clk)
        rst |=> (!fab_req_o && !flush_req_o && !bridge_rst_o && !busy_o && !err_o));
endmodule

bind bridge_rst_seq brs_checker i_brs_checker (
    .clk           (clk),
    .rst           (rst),
    .start_i       (start_i),
    .hs_en_i       (hs_en_i),
    .fab_ack_i     (fab_ack_i),
    .flush_ack_i   (flush_ack_i),
    .reconf_done_i (reconf_done_i),
    .fab_req_o     (fab_req_o),
    .flush_req_o   (flush_req_o),
    .bridge_rst_o  (bridge_rst_o),
    .busy_o        (busy_o),
    .done_o        (done_o),
    .err_o         (err_o),
    .err_state_o   (err_state_o)
);

// File: tb/test_bridge_rst_seq.sv
`timescale 1ns/1ps
module test_bridge_rst_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        hs_en = 1'b0;
    logic        fab_ack = 1'b0;
    logic        flush_ack = 1'b0;
    logic        reconf = 1'b0;
    logic [15:0] limit = 16'd0;
    logic        fab_req, flush_req, bridge_rst, busy, done, err;
    logic [2:0]  err_state;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit started = 0;

    always #4 clk = ~clk;

    bridge_rst_seq #(.TMO_W(16)) i_bridge_rst_seq (
        .clk           (clk),
        .rst           (rst),
        .start_i       (start),
        .hs_en_i       (hs_en),
        .fab_ack_i     (fab_ack),
        .flush_ack_i   (flush_ack),
        .reconf_done_i (reconf),
        .tmo_limit_i   (limit),
        .fab_req_o     (fab_req),
        .flush_req_o   (flush_req),
        .bridge_rst_o  (bridge_rst),
        .busy_o        (busy),
        .done_o        (done),
        .err_o         (err),
        .err_state_o   (err_state)
    );

    // Behavioural reference: step number 0 idle, 1 warn wait, 2 flush wait,
    // 3 reset held, 4 released, 5 warn withdrawn, 6 flush low wait, 7 warn low wait
    int m_step = 0;
    int m_cnt  = 0;
    bit m_hs   = 0;
    bit m_done = 0;
    bit m_err  = 0;
    int m_code = 0;

    task automatic m_wait(bit ok, int next, int code);
        if (ok) begin
            m_step = next;
            m_cnt  = 0;
        end else if (limit != 0 && m_cnt + 1 >= int'(limit)) begin
            m_err  = 1;
            m_code = code;
            m_step = 0;
            m_cnt  = 0;
        end else begin
            m_cnt = m_cnt + 1;
        end
    endtask

    always @(posedge clk) begin
        started = 1;
        if (rst) begin
            m_step = 0; m_cnt = 0; m_hs = 0; m_done = 0; m_err = 0; m_code = 0;
        end else begin
            m_done = 0;
            case (m_step)
                0: if (start) begin
                    m_err = 0; m_code = 0; m_hs = hs_en; m_cnt = 0;
                    m_step = hs_en ? 1 : 2;
                end
                1: m_wait(fab_ack, 2, 1);
                2: m_wait(flush_ack, 3, 2);
                3: if (reconf) m_step = 4;
                4: m_step = 5;
                5: begin m_step = 6; m_cnt = 0; end
                6: begin
                    m_wait(!flush_ack, m_hs ? 7 : 0, 3);
                    if (!flush_ack && !m_hs) m_done = 1;
                end
                7: begin
                    m_wait(!fab_ack, 0, 4);
                    if (!fab_ack) m_done = 1;
                end
                default: m_step = 0;
            endcase
        end
    end

    task automatic chk(string req, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (started) begin
            chk("R1", fab_req,    int'(m_hs && m_step >= 1 && m_step <= 4), "model fab_req");
            chk("R3", flush_req,  int'(m_step >= 2 && m_step <= 5), "model flush_req");
            chk("R4", bridge_rst, int'(m_step == 3), "model bridge_rst");
            chk("R8", busy,       int'(m_step != 0), "model busy");
            chk("R7", done,       int'(m_done), "model done");
            chk("R9", err,        int'(m_err), "model err");
            chk("R9", err_state,  m_code, "model err_state");
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            $display("FAIL R7 watchdog: actual hung expected finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_start();
        start = 1'b1;
        step(1);
        start = 1'b0;
    endtask

    initial begin
        step(3);
        chk("R10", fab_req, 0, "reset fab_req");
        chk("R10", flush_req, 0, "reset flush_req");
        chk("R10", bridge_rst, 0, "reset bridge_rst");
        chk("R10", busy, 0, "reset busy");
        rst = 1'b0;
        step(2);

        // Full run with warning handshake
        limit = 16'd20; hs_en = 1'b1;
        pulse_start();
        chk("R1", fab_req, 1, "warn request after start");
        chk("R8", busy, 1, "busy after start");
        step(3);
        chk("R2", flush_req, 0, "no flush before warn ack");
        fab_ack = 1'b1;
        step(1);
        chk("R2", flush_req, 1, "flush after warn ack");
        chk("R4", bridge_rst, 0, "no reset before flush ack");
        step(2);
        flush_ack = 1'b1;
        step(1);
        chk("R4", bridge_rst, 1, "reset after flush ack");
        pulse_start();
        chk("R8", busy, 1, "start while busy ignored");
        chk("R8", fab_req, 1, "start while busy keeps request");
        step(3);
        chk("R5", bridge_rst, 1, "reset held until reconf done");
        reconf = 1'b1;
        step(1);
        reconf = 1'b0;
        chk("R5", bridge_rst, 0, "reset released");
        chk("R6", fab_req, 1, "warn still held at release");
        chk("R6", flush_req, 1, "flush still held at release");
        step(1);
        chk("R6", fab_req, 0, "warn withdrawn first");
        chk("R6", flush_req, 1, "flush withdrawn second");
        step(1);
        chk("R6", flush_req, 0, "flush withdrawn");
        step(2);
        chk("R7", done, 0, "no done while flush ack high");
        flush_ack = 1'b0;
        step(1);
        chk("R7", done, 0, "no done while warn ack high");
        chk("R7", busy, 1, "busy while warn ack high");
        fab_ack = 1'b0;
        step(1);
        chk("R7", done, 1, "done after both acks low");
        chk("R7", busy, 0, "idle at done");
        step(1);
        chk("R7", done, 0, "done lasts one cycle");

        // Run without warning handshake
        hs_en = 1'b0;
        pulse_start();
        chk("R3", flush_req, 1, "flush right after start");
        chk("R1", fab_req, 0, "no warn request when disabled");
        flush_ack = 1'b1;
        step(1);
        chk("R4", bridge_rst, 1, "reset without handshake");
        reconf = 1'b1;
        step(1);
        reconf = 1'b0;
        step(2);
        flush_ack = 1'b0;
        step(1);
        chk("R7", done, 1, "done without warn wait");

        // Timeout in flush wait
        limit = 16'd5;
        pulse_start();
        step(4);
        chk("R9", err, 0, "no timeout before limit");
        step(1);
        chk("R9", err, 1, "timeout at limit");
        chk("R9", err_state, 2, "flush high code");
        chk("R9", flush_req, 0, "request dropped on timeout");
        chk("R9", bridge_rst, 0, "reset untouched on timeout");
        step(4);
        chk("R9", err, 1, "error sticky");

        // Ack exactly at limit edge, then flush timeout
        limit = 16'd4; hs_en = 1'b1;
        pulse_start();
        chk("R9", err, 0, "error cleared by start");
        step(3);
        fab_ack = 1'b1;
        step(1);
        chk("R9", err, 0, "ack at limit edge accepted");
        chk("R9", flush_req, 1, "flush after late ack");
        step(3);
        chk("R9", err, 0, "flush wait before limit");
        step(1);
        chk("R9", err_state, 2, "flush high code again");
        fab_ack = 1'b0;
        step(1);

        // Timeout waiting for warn ack
        limit = 16'd3;
        pulse_start();
        step(2);
        chk("R9", err, 0, "warn wait before limit");
        step(1);
        chk("R9", err_state, 1, "warn high code");

        // Timeout waiting for flush ack to drop
        limit = 16'd10;
        pulse_start();
        fab_ack = 1'b1;
        step(1);
        flush_ack = 1'b1;
        step(1);
        reconf = 1'b1;
        step(1);
        reconf = 1'b0;
        step(2);
        step(9);
        chk("R9", err, 0, "drain wait before limit");
        step(1);
        chk("R9", err_state, 3, "flush low code");
        fab_ack = 1'b0; flush_ack = 1'b0;
        step(1);

        // Limit zero never expires
        limit = 16'd0; hs_en = 1'b0;
        pulse_start();
        step(40);
        chk("R9", err, 0, "no timeout with zero limit");
        chk("R9", busy, 1, "still waiting with zero limit");

        // Reset in the middle of a run
        flush_ack = 1'b1;
        step(1);
        chk("R4", bridge_rst, 1, "reset held before sync reset");
        rst = 1'b1;
        step(1);
        rst = 1'b0;
        chk("R10", bridge_rst, 0, "sync reset drops bridge reset");
        chk("R10", flush_req, 0, "sync reset drops flush");
        chk("R10", busy, 0, "sync reset idles");
        flush_ack = 1'b0;
        step(2);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule